// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Load Interlock

This block produces a single center-aligned pulse-width-modulated output from an up/down counter. Software programs a period limit (modulus), a clock divider selection and a duty value into shadow registers through a small register port. The generator runs from an active copy of these values. The shadow set is copied into the active set only at a reload point, which is the moment the counter returns to zero, and only when software has set a load-permit bit. Hardware clears that bit after the copy, so a half-written parameter set is never used.

A reload flag is raised at every reload point, whether or not a copy took place. The flag stays set until software reads the control register while the flag is 1 and then writes a 0 to the flag bit. An interrupt output is high while the flag and an interrupt-enable bit are both 1. Raising the run enable forces a reload point at once. Parameters are therefore loaded on start-up if the permit bit is set, and the flag is set either way.

Top module: `cpwm_top`

## Requirements
- R1: Writes to the modulus (address 1) or duty (address 2) shadow registers do not change the waveform while the load-permit bit (control bit 0) is 0. The shadow value reads back at its own address.
- R2: When the load-permit bit is set during a run, it still reads 1 after the write. The new shadow values govern the waveform only from the next reload point.
- R3: Hardware clears the load-permit bit at the reload point that copies the shadow set. Writing 0 to that bit has no effect.
- R4: The reload flag (control bit 2) is set at every reload point. The period between reload points is 2 x modulus x divider clock cycles.
- R5: The reload flag clears only when a write of 0 to bit 2 follows a read of the control register (address 0, read strobe) that saw the flag at 1 after its last set. A write of 0 without that read leaves the flag at 1.
- R6: The interrupt output equals the reload flag ANDed with the interrupt-enable bit (control bit 1).
- R7: Raising the run enable causes an immediate reload point: the shadow set is copied if load-permit is 1, and the flag is set regardless. With load-permit at 0, the previous active values stay in force.
- R8: The counter runs 0 up to the modulus and back down to 0. The output is high while the count is below the duty value, so each period holds (2 x duty - 1) x divider high cycles. Duty 0 gives a constant low output, and duty at or above the modulus gives a constant high output.
- R9: Control bits [4:3] select the counter clock divider: 0 selects /1, 1 selects /2, 2 selects /4 and 3 selects /8. The selection is shadowed like the other parameters.
- R10: After reset, every register reads 0 and the PWM and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; used to arm the flag clear |
| reg_addr | input | 2 | Register select: 0 control, 1 modulus, 2 duty, 3 reads 0 |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register, combinational |
| pwm_en | input | 1 | Run enable; a rising edge forces a reload point |
| pwm_out | output | 1 | Center-aligned PWM output |
| irq_out | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the run enable and register strobes are synchronous to the clock. They also assume that a register write and a reload point meet only in the ways the stimulus produces. The stimulus drives every input half a cycle away from the active edge. It changes modulus, duty and divider only while the generator is stopped, or through the shadow registers. Measurements start from a reload point found by polling the flag, and they span exactly one period, so the high-cycle count does not depend on phase.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_MOD   = 2'd1,
    REG_DUTY  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam int CTL_LDOK = 0;
  localparam int CTL_IEN  = 1;
  localparam int CTL_FLAG = 2;
  localparam int CTL_PSEL = 3;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              reload_i,
  output logic [CNT_W-1:0]  act_mod_o,
  output logic [CNT_W-1:0]  act_duty_o,
  output logic [PSEL_W-1:0] act_psel_o,
  output logic              flag_o,
  output logic              ien_o
);
  logic [CNT_W-1:0]  sh_mod_q, sh_mod_d, sh_duty_q, sh_duty_d;
  logic [PSEL_W-1:0] sh_psel_q, sh_psel_d;
  logic [CNT_W-1:0]  act_mod_q, act_mod_d, act_duty_q, act_duty_d;
  logic [PSEL_W-1:0] act_psel_q, act_psel_d;
  logic ldok_q, ldok_d, ien_q, ien_d, flag_q, flag_d, armed_q, armed_d;
  logic ctrl_wr, ctrl_rd, xfer;

  always_comb begin
    ctrl_wr = wr_i && (addr_i == REG_CTRL);
    ctrl_rd = rd_i && (addr_i == REG_CTRL);
    xfer    = reload_i && ldok_q;

    sh_mod_d  = (wr_i && addr_i == REG_MOD)  ? wdata_i : sh_mod_q;
    sh_duty_d = (wr_i && addr_i == REG_DUTY) ? wdata_i : sh_duty_q;
    sh_psel_d = ctrl_wr ? wdata_i[CTL_PSEL +: PSEL_W] : sh_psel_q;
    ien_d     = ctrl_wr ? wdata_i[CTL_IEN] : ien_q;

    act_mod_d  = xfer ? sh_mod_q  : act_mod_q;
    act_duty_d = xfer ? sh_duty_q : act_duty_q;
    act_psel_d = xfer ? sh_psel_q : act_psel_q;

    ldok_d = ldok_q;
    if (xfer) ldok_d = 1'b0;
    if (ctrl_wr && wdata_i[CTL_LDOK]) ldok_d = 1'b1;

    armed_d = armed_q;
    if (ctrl_rd && flag_q) armed_d = 1'b1;
    if (ctrl_wr || reload_i) armed_d = 1'b0;

    flag_d = flag_q;
    if (ctrl_wr && !wdata_i[CTL_FLAG] && armed_q) flag_d = 1'b0;
    if (reload_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mod_q   <= '0;
      sh_duty_q  <= '0;
      sh_psel_q  <= '0;
      act_mod_q  <= '0;
      act_duty_q <= '0;
      act_psel_q <= '0;
      ldok_q     <= 1'b0;
      ien_q      <= 1'b0;
      flag_q     <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      sh_mod_q   <= sh_mod_d;
      sh_duty_q  <= sh_duty_d;
      sh_psel_q  <= sh_psel_d;
      act_mod_q  <= act_mod_d;
      act_duty_q <= act_duty_d;
      act_psel_q <= act_psel_d;
      ldok_q     <= ldok_d;
      ien_q      <= ien_d;
      flag_q     <= flag_d;
      armed_q    <= armed_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTL_LDOK] = ldok_q;
        rdata_o[CTL_IEN]  = ien_q;
        rdata_o[CTL_FLAG] = flag_q;
        rdata_o[CTL_PSEL +: PSEL_W] = sh_psel_q;
      end
      REG_MOD:  rdata_o = sh_mod_q;
      REG_DUTY: rdata_o = sh_duty_q;
      default:  rdata_o = '0;
    endcase
  end

  assign act_mod_o  = act_mod_q;
  assign act_duty_o = act_duty_q;
  assign act_psel_o = act_psel_q;
  assign flag_o     = flag_q;
  assign ien_o      = ien_q;

  // Active set moves only at a reload point
  assert_active_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> $stable({act_mod_q, act_duty_q, act_psel_q}));
  // Copy consumes the permit bit unless software sets it again
  assert_ldok_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && ldok_q && !ctrl_wr) |=> !ldok_q);
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> flag_q);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctrl_wr) |=> flag_q);
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [CNT_W-1:0]  mod_i,
  output logic              running_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              reload_o
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic             en_q, en_d, down_q, down_d;
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, tick, bottom;

  always_comb begin
    pre_lim = {PRE_W{1'b1}} >> (PRE_W - int'(psel_i));
    start   = en_i && !en_q;
    tick    = en_q && (pre_q == pre_lim);
    bottom  = tick && (down_q ? (cnt_q == CNT_W'(1)) : (cnt_q >= mod_i));
    reload_o = start || bottom;

    en_d   = en_i;
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    down_d = down_q;
    if (!en_i || start) begin
      pre_d  = '0;
      cnt_d  = '0;
      down_d = 1'b0;
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) begin
        if (down_q) begin
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) down_d = 1'b0;
        end else if (cnt_q >= mod_i) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q + CNT_W'(1) == mod_i) down_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign running_o = en_q;
  assign cnt_o     = cnt_q;

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q <= mod_i));
  assert_reload_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bottom |=> (cnt_q == '0));
  assert_prescale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_i && !tick) |=> (pre_q == $past(pre_q) + PRE_W'(1)));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int CNT_W = 8
) (
  input  logic             running_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic             pwm_o
);
  logic duty_zero, duty_full;

  always_comb begin
    duty_zero = (duty_i == '0);
    duty_full = (duty_i >= mod_i);
    pwm_o = running_i && !duty_zero && (duty_full || (cnt_i < duty_i));
  end
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
  parameter int CNT_W  = 8,
  parameter int PSEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             pwm_en,
  output logic             pwm_out,
  output logic             irq_out
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [CNT_W-1:0]  act_mod, act_duty, cnt;
  logic [PSEL_W-1:0] act_psel;
  logic              reload, running, flag, ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cpwm_regs #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .reload_i(reload),
    .act_mod_o(act_mod), .act_duty_o(act_duty), .act_psel_o(act_psel),
    .flag_o(flag), .ien_o(ien)
  );

  cpwm_counter #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n),
    .en_i(pwm_en), .psel_i(act_psel), .mod_i(act_mod),
    .running_o(running), .cnt_o(cnt), .reload_o(reload)
  );

  cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .running_i(running), .cnt_i(cnt), .duty_i(act_duty),
    .mod_i(act_mod), .pwm_o(pwm_out)
  );

  assign irq_out = flag && ien;

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reload && ien && !reg_wr) |=> irq_out);
endmodule

// File: tb/cpwm_top_tb.sv
`timescale 1ns/1ps
module cpwm_top_tb;
  localparam int CW = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_MOD = 2'd1, A_DUTY = 2'd2;
  // {modulus, duty, divider select}
  localparam logic [17:0] VECS [8] = '{
    {8'd3, 8'd1, 2'd0}, {8'd3, 8'd2, 2'd0}, {8'd3, 8'd0, 2'd0},
    {8'd3, 8'd3, 2'd0}, {8'd5, 8'd2, 2'd1}, {8'd4, 8'd1, 2'd2},
    {8'd2, 8'd1, 2'd3}, {8'd6, 8'd7, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n, reg_wr, reg_rd, pwm_en, pwm_out, irq_out;
  logic [1:0] reg_addr;
  logic [CW-1:0] reg_wdata, reg_rdata;
  int tests = 0, fails = 0;
  logic ien_sh = 1'b0;
  logic [1:0] psel_sh = 2'd0;

  always #4 clk = ~clk;

  cpwm_top #(.CNT_W(CW), .PSEL_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .irq_out(irq_out)
  );

  function automatic logic [CW-1:0] ctrl_val(logic ld, logic ie, logic [1:0] ps);
    return {3'b000, ps, 1'b0, ie, ld};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic reg_peek(input logic [1:0] a, output logic [CW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic read_arm(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Clear the flag, then stop at the first sample after the next reload point
  task automatic sync_reload();
    logic [CW-1:0] d;
    read_arm(A_CTRL);
    reg_write(A_CTRL, ctrl_val(1'b0, ien_sh, psel_sh));
    reg_peek(A_CTRL, d);
    while (!d[2]) begin
      @(negedge clk);
      reg_peek(A_CTRL, d);
    end
  endtask

  task automatic measure(input int p, output int high, output int per,
                         output int ld0, output int irq0);
    high = 0; per = -1; ld0 = 0; irq0 = 0;
    for (int i = 0; i <= p; i++) begin
      if (i > 0) @(negedge clk);
      reg_addr  = A_CTRL;
      reg_rd    = (i == 0);
      reg_wr    = (i == 1);
      reg_wdata = ctrl_val(1'b0, ien_sh, psel_sh);
      #1;
      if (i < p && pwm_out) high++;
      if (i == 0) begin ld0 = int'(reg_rdata[0]); irq0 = int'(irq_out); end
      if (i >= 2 && per < 0 && reg_rdata[2]) per = i;
    end
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] d;
    int high, per, ld0, irq0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; pwm_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    reg_peek(A_CTRL, d); check("R10 ctrl", int'(d), 0);
    reg_peek(A_MOD, d);  check("R10 mod", int'(d), 0);
    check("R10 pwm", int'(pwm_out), 0);
    check("R10 irq", int'(irq_out), 0);

    // R8 R9 R7: table of waveforms, loaded by enable with permit set
    foreach (VECS[k]) begin
      int m, du, ps, div, p, eh;
      m = int'(VECS[k][17:10]); du = int'(VECS[k][9:2]); ps = int'(VECS[k][1:0]);
      div = 1 << ps; p = 2 * m * div;
      eh = (du == 0) ? 0 : (du >= m) ? p : (2 * du - 1) * div;
      ien_sh = 1'b0; psel_sh = VECS[k][1:0];
      @(negedge clk); pwm_en = 1'b0;
      reg_write(A_MOD, VECS[k][17:10]);
      reg_write(A_DUTY, VECS[k][9:2]);
      reg_write(A_CTRL, ctrl_val(1'b1, 1'b0, psel_sh));
      @(negedge clk); pwm_en = 1'b1;
      @(negedge clk);
      measure(p, high, per, ld0, irq0);
      check($sformatf("R8 R9 high v%0d", k), high, eh);
      check($sformatf("R4 R9 period v%0d", k), per, p);
      check($sformatf("R3 R7 permit cleared v%0d", k), ld0, 0);
    end

    // R1: shadow duty write without permit leaves the waveform
    ien_sh = 1'b0; psel_sh = 2'd0;
    @(negedge clk); pwm_en = 1'b0;
    reg_write(A_MOD, 8'd4);
    reg_write(A_DUTY, 8'd1);
    reg_write(A_CTRL, ctrl_val(1'b1, 1'b0, 2'd0));
    @(negedge clk); pwm_en = 1'b1;
    @(negedge clk);
    reg_write(A_DUTY, 8'd3);
    sync_reload();
    measure(8, high, per, ld0, irq0);
    check("R1 waveform kept", high, 1);
    reg_peek(A_DUTY, d); check("R1 shadow readback", int'(d), 3);

    // R2 R3 R6: permit takes effect at the next reload only
    ien_sh = 1'b1;
    reg_write(A_CTRL, ctrl_val(1'b1, 1'b1, 2'd0));
    reg_peek(A_CTRL, d); check("R2 permit pending", int'(d[0]), 1);
    sync_reload();
    measure(8, high, per, ld0, irq0);
    check("R2 new duty after reload", high, 5);
    check("R3 permit cleared", ld0, 0);
    check("R6 irq with flag and enable", irq0, 1);
    reg_write(A_CTRL, ctrl_val(1'b0, 1'b1, 2'd0));
    reg_peek(A_CTRL, d); check("R3 write 0 keeps permit 0", int'(d[0]), 0);

    // R5 R6: flag clear protocol, generator stopped
    @(negedge clk); pwm_en = 1'b0;
    @(negedge clk);
    reg_peek(A_CTRL, d);
    check("R5 flag set before clear", int'(d[2]), 1);
    check("R6 irq high", int'(irq_out), 1);
    reg_write(A_CTRL, ctrl_val(1'b0, 1'b1, 2'd0));
    reg_peek(A_CTRL, d); check("R5 write 0 without read", int'(d[2]), 1);
    reg_write(A_CTRL, ctrl_val(1'b0, 1'b0, 2'd0));
    check("R6 irq masked", int'(irq_out), 0);
    reg_peek(A_CTRL, d); check("R6 flag still set", int'(d[2]), 1);
    read_arm(A_CTRL);
    reg_write(A_CTRL, ctrl_val(1'b0, 1'b1, 2'd0));
    reg_peek(A_CTRL, d); check("R5 read then write 0", int'(d[2]), 0);
    check("R6 irq low after clear", int'(irq_out), 0);

    // R7: enable with permit clear still flags; active values retained
    @(negedge clk); pwm_en = 1'b1;
    @(negedge clk);
    reg_peek(A_CTRL, d);
    check("R7 flag on enable", int'(d[2]), 1);
    check("R7 irq on enable", int'(irq_out), 1);
    check("R7 active duty kept", int'(pwm_out), 1);
    ien_sh = 1'b1;
    measure(8, high, per, ld0, irq0);
    check("R7 high with kept values", high, 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule